// File: doc/BRIEF.md
# Serial Switch Register Access Master

This block lets on-chip logic read and write the configuration and counter registers of an external Ethernet switch device. The device is reached over three wires: a select line, a serial clock and one bidirectional data line. Each line has its own output value and output-enable pin, so the pad ring decides when the block drives it. The host side offers a single request: a write/read flag, a table select, an 8-bit register address and 16 bits of write data. When the transfer is over, the block returns read data together with a one-cycle completion pulse.

Writes go out as a short frame with select asserted. Reads begin with a long run of ones sent with select low. The master then releases the data line, gives the device two clocks to turn the bus around and shifts in a 32-bit response. For the 16-bit table that response holds two neighbouring registers, and the low address bit picks one of them. All serial timing comes from counts of system clock cycles. These counts are derived from the system clock frequency and the minimum half-period and setup times, all given in nanoseconds.

Top module: `swreg_serial_master`

## Requirements
- R1: After reset, busy, done, all three output enables, the select value, the serial clock value and the read data register are all 0.
- R2: A request is taken when req_valid is high while busy is low, and busy is high in the next cycle. busy stays high until the completion pulse. A request presented while busy is high is ignored: it gives no serial traffic and no completion.
- R3: A write sends 27 bits, MSB first, with select high at every rising clock of the frame. The bits are 1, 0, 1, then address bits 7..0, then write data bits 15..0.
- R4: A read sends 46 bits with select low for the whole transaction. The bits are 32 ones, then 0,1,1,0, then the table bit, then 0,0, then address bits 6..1, then a final 0.
- R5: The clock is low for HALF+SETUP cycles and high for HALF cycles on every frame bit. A new data value appears HALF cycles after the falling edge, and the data value does not change while the clock is high.
- R6: During a read, the data output enable drops after the frame. Two turnaround clocks follow, and then 32 bits are captured MSB first, each one in the last cycle before a rising edge.
- R7: After the frame of a write, or after the capture of a read, exactly two more rising clocks follow. The clock then stays low for HALF cycles, and all output enables drop in the cycle that done is high. A write therefore has 29 rising edges in total and a read has 82.
- R8: For table 0, an odd address returns the first 16 received bits and an even address returns the last 16, zero-extended to 32 bits.
- R9: For table 1, all 32 received bits are returned, with the first received bit in bit 31.
- R10: done is high for exactly one cycle, and rdata is valid in that cycle. A write leaves rdata unchanged.
- R11: In the first cycle of a transaction all three output enables are high with every output value 0. The first rising clock comes 3*HALF+SETUP cycles after busy rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_table | input | 1 | Table select (0 = 16-bit registers, 1 = 32-bit counters) |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with done |
| sel_o | output | 1 | Select line value |
| sel_oe | output | 1 | Select line output enable |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Serial clock output enable |
| sd_o | output | 1 | Serial data value |
| sd_oe | output | 1 | Serial data output enable |
| sd_i | input | 1 | Serial data from the device |

## Verification
The completion pulse of one transaction and the acceptance of the next request can fall in the same cycle. busy drops in the cycle where done is high, so a request waiting at that moment is taken at once. The bench queues its requests back to back, which makes every transaction after the first start in the done cycle of the one before. The scoreboard then checks that the pulse still returns the earlier transaction's read data, and that the new frame starts with a full preparation interval and its own bit pattern. A request issued during a running transfer must leave no trace: no extra completion and no change to the frame in flight.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

    localparam int FRAME_W    = 46;
    localparam int WR_BITS    = 27;
    localparam int RD_BITS    = 46;
    localparam int RESP_W     = 32;
    localparam int PREAMBLE_W = 32;
    localparam int TURN_CLKS  = 2;
    localparam int TAIL_CLKS  = 2;
    localparam int CNT_W      = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREP,
        ST_SELUP,
        ST_FRAME,
        ST_GAP,
        ST_TURN,
        ST_CAPT,
        ST_TAIL,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic        wr;
        logic        tbl;
        logic [7:0]  addr;
        logic [15:0] wdata;
    } req_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   len;
    } frame_t;

    // Left-aligned command frame; len gives how many leading bits are sent.
    function automatic frame_t build_frame(req_t r);
        frame_t f;
        if (r.wr) begin
            f.bits = {3'b101, r.addr, r.wdata, {(FRAME_W-WR_BITS){1'b0}}};
            f.len  = CNT_W'(WR_BITS);
        end else begin
            f.bits = {{PREAMBLE_W{1'b1}}, 4'b0110, r.tbl, 2'b00, r.addr[6:1], 1'b0};
            f.len  = CNT_W'(RD_BITS);
        end
        return f;
    endfunction

    // Table 0 answers with two 16-bit registers; the address LSB selects one.
    function automatic logic [RESP_W-1:0] pick_rdata(logic tbl, logic odd,
                                                     logic [RESP_W-1:0] rx);
        if (tbl)
            return rx;
        else if (odd)
            return {16'h0000, rx[RESP_W-1:RESP_W-16]};
        else
            return {16'h0000, rx[15:0]};
    endfunction

endpackage

// File: rtl/swreg_bit_timer.sv
module swreg_bit_timer #(
    parameter int HALF_CYC  = 750,
    parameter int SETUP_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clocked,
    output logic sck_hi,
    output logic upd,
    output logic smp,
    output logic seg_end
);
    localparam int LOW_CYC = HALF_CYC + SETUP_CYC;
    localparam int BIT_CYC = LOW_CYC + HALF_CYC;
    localparam int CW      = $clog2(BIT_CYC + 1);

    logic [CW-1:0] cnt;
    logic          bit_last;
    logic          wait_last;

    assign bit_last  = (cnt == CW'(BIT_CYC - 1));
    assign wait_last = (cnt == CW'(HALF_CYC - 1));
    assign seg_end   = run && (clocked ? bit_last : wait_last);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (seg_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign sck_hi = run && clocked && (cnt >= CW'(LOW_CYC));
    assign upd    = run && clocked && (cnt == CW'(HALF_CYC));
    assign smp    = run && clocked && (cnt == CW'(LOW_CYC - 1));

    // R5: the phase counter never runs past one bit period
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CW'(BIT_CYC)));

    // R5: data updates and samples happen only in the low phase
    assert_low_phase_R5: assert property (@(posedge clk) disable iff (rst)
        (upd || smp) |-> !sck_hi);

endmodule

// File: rtl/swreg_shift_unit.sv
module swreg_shift_unit
    import swreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               upd,
    input  logic               smp,
    input  logic               sd_i,
    output logic               sd_bit,
    output logic [RESP_W-1:0]  rx_word
);
    logic [FRAME_W-1:0] tx;
    logic               sd_q;
    logic [RESP_W-1:0]  rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx   <= '0;
            sd_q <= 1'b0;
            rx   <= '0;
        end else begin
            if (load) begin
                tx   <= frame_bits;
                sd_q <= 1'b0;
            end else if (upd) begin
                sd_q <= tx[FRAME_W-1];
                tx   <= {tx[FRAME_W-2:0], 1'b0};
            end
            if (smp)
                rx <= {rx[RESP_W-2:0], sd_i};
        end
    end

    assign sd_bit  = sd_q;
    assign rx_word = rx;

endmodule

// File: rtl/swreg_serial_master.sv
module swreg_serial_master
    import swreg_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int HALF_NS  = 3000,
    parameter int SETUP_NS = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_table,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rdata,
    output logic        sel_o,
    output logic        sel_oe,
    output logic        sck_o,
    output logic        sck_oe,
    output logic        sd_o,
    output logic        sd_oe,
    input  logic        sd_i
);
    localparam int HALF_RAW  = (HALF_NS * CLK_MHZ + 999) / 1000;
    localparam int SETUP_RAW = (SETUP_NS * CLK_MHZ + 999) / 1000;
    localparam int HALF_CYC  = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;

    state_e             state;
    req_t               req_q;
    frame_t             frm;
    logic [CNT_W-1:0]   bitcnt;
    logic [CNT_W-1:0]   need;
    logic               clocked;
    logic               sck_hi, upd, smp, seg_end;
    logic               last_bit, seg_done, load;
    logic               sd_bit;
    logic [RESP_W-1:0]  rx_word;

    assign frm     = build_frame(req_q);
    assign clocked = (state == ST_FRAME) || (state == ST_TURN) ||
                     (state == ST_CAPT)  || (state == ST_TAIL);

    always_comb begin
        case (state)
            ST_FRAME: need = frm.len;
            ST_TURN:  need = CNT_W'(TURN_CLKS);
            ST_CAPT:  need = CNT_W'(RESP_W);
            ST_TAIL:  need = CNT_W'(TAIL_CLKS);
            default:  need = CNT_W'(1);
        endcase
    end

    assign last_bit = seg_end && (bitcnt == need - 1'b1);
    assign seg_done = clocked ? last_bit : seg_end;
    assign load     = (state == ST_SELUP) && seg_end;

    swreg_bit_timer #(
        .HALF_CYC  (HALF_CYC),
        .SETUP_CYC (SETUP_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .clocked (clocked),
        .sck_hi  (sck_hi),
        .upd     (upd),
        .smp     (smp),
        .seg_end (seg_end)
    );

    swreg_shift_unit u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .frame_bits (frm.bits),
        .upd        (upd && (state == ST_FRAME)),
        .smp        (smp && (state == ST_CAPT)),
        .sd_i       (sd_i),
        .sd_bit     (sd_bit),
        .rx_word    (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            req_q  <= '0;
            bitcnt <= '0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            if (seg_done)
                bitcnt <= '0;
            else if (clocked && seg_end)
                bitcnt <= bitcnt + 1'b1;

            case (state)
                ST_IDLE: if (req_valid) begin
                    req_q <= '{wr: req_write, tbl: req_table,
                               addr: req_addr, wdata: req_wdata};
                    state <= ST_PREP;
                end
                ST_PREP:   if (seg_end)  state <= ST_SELUP;
                ST_SELUP:  if (seg_end)  state <= ST_FRAME;
                ST_FRAME:  if (last_bit) state <= ST_GAP;
                ST_GAP:    if (seg_end)  state <= req_q.wr ? ST_TAIL : ST_TURN;
                ST_TURN:   if (last_bit) state <= ST_CAPT;
                ST_CAPT:   if (last_bit) state <= ST_TAIL;
                ST_TAIL:   if (last_bit) state <= ST_FINISH;
                ST_FINISH: if (seg_end) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                    if (!req_q.wr)
                        rdata <= pick_rdata(req_q.tbl, req_q.addr[0], rx_word);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign sel_oe = busy;
    assign sck_oe = busy;
    assign sd_oe  = busy && (req_q.wr || (state == ST_PREP) ||
                             (state == ST_SELUP) || (state == ST_FRAME));
    assign sel_o  = req_q.wr && ((state == ST_SELUP) || (state == ST_FRAME));
    assign sck_o  = sck_hi;
    assign sd_o   = (state == ST_FRAME) ? sd_bit : 1'b0;

    // R2: a captured request is held while the transfer runs
    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(req_q));

    // R4: select stays low throughout a read
    assert_read_nosel_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !req_q.wr) |-> !sel_o);

    // R5: data is steady while the clock is high
    assert_sd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (sck_o && $past(sck_o)) |-> $stable(sd_o));

    // R6: the data pin is never driven while response bits come in
    assert_rx_dir_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAPT) |-> !sd_oe);

    // R7: every driver is released in the completion cycle
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sel_oe && !sck_oe && !sd_oe && !sck_o));

    // R10: completion lasts one cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/swreg_serial_master_tb.sv
module swreg_serial_master_tb;
    localparam int HALF = 4;
    localparam int LOW  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_table = 1'b0;
    logic [7:0]  req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic        sd_i = 1'b0;
    logic        busy, done, sel_o, sel_oe, sck_o, sck_oe, sd_o, sd_oe;
    logic [31:0] rdata;

    always #2 clk = ~clk;

    swreg_serial_master #(.CLK_MHZ(250), .HALF_NS(16), .SETUP_NS(8)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_table(req_table), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .sel_o(sel_o), .sel_oe(sel_oe),
        .sck_o(sck_o), .sck_oe(sck_oe), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
    );

    typedef struct {
        logic [45:0] frame;
        int          len;
        bit          wr;
        logic [31:0] rdata;
        int          rises;
    } item_t;

    item_t       q[$];
    int          checks = 0;
    int          fails  = 0;
    logic [31:0] model_rdata = '0;
    logic [31:0] slave_word  = '0;

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(bit wr, bit tbl, logic [7:0] a, logic [15:0] d, logic [31:0] resp);
        item_t it;
        do @(negedge clk); while (busy);
        it.wr = wr;
        if (wr) begin
            it.frame = {3'b101, a, d, 19'b0};
            it.len   = 27;
            it.rises = 29;
        end else begin
            it.frame = {32'hFFFF_FFFF, 4'b0110, tbl, 2'b00, a[6:1], 1'b0};
            it.len   = 46;
            it.rises = 82;
            model_rdata = tbl ? resp : (a[0] ? {16'h0, resp[31:16]} : {16'h0, resp[15:0]});
        end
        it.rdata   = model_rdata;
        slave_word = resp;
        q.push_back(it);
        req_valid = 1'b1; req_write = wr; req_table = tbl; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", busy, 1);
    endtask

    // Monitor and device model: sample at the falling system edge.
    initial begin
        item_t       cur;
        logic [45:0] cap;
        int          rises, lowrun, highrun, pre_cnt, e;
        bit          prev_sck, prev_busy, prev_sd, tbad, selbad, oebad, want_done_low;
        rises = 0; lowrun = 0; highrun = 0; pre_cnt = 0; e = 0; cap = '0;
        prev_sck = 0; prev_busy = 0; prev_sd = 0; tbad = 0; selbad = 0; oebad = 0;
        want_done_low = 0;
        cur = '{frame: '0, len: 0, wr: 0, rdata: '0, rises: 0};
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (want_done_low) begin
                    check(done == 1'b0, "R10 done one cycle", done, 0);
                    want_done_low = 0;
                end
                if (busy && !prev_busy) begin
                    if (q.size() > 0) cur = q[0];
                    rises = 0; cap = '0; lowrun = 0; highrun = 0; pre_cnt = 0; e = 0;
                    tbad = 0; selbad = 0; oebad = 0;
                    check(sel_oe && sck_oe && sd_oe && !sel_o && !sck_o && !sd_o,
                          "R11 start state", {sel_oe, sck_oe, sd_oe, sel_o, sck_o, sd_o}, 6'b111000);
                end
                if (busy) begin
                    if (rises == 0 && !sck_o) pre_cnt++;
                    if (sck_o) begin
                        if (!prev_sck) begin
                            rises++;
                            if (rises > 1 && rises <= cur.len && lowrun != LOW) tbad = 1;
                            lowrun = 0;
                            if (rises <= cur.len) begin
                                cap[46 - rises] = sd_o;
                                if (sel_o != cur.wr) selbad = 1;
                            end else begin
                                if (sel_o) selbad = 1;
                                if (!cur.wr && sd_oe) oebad = 1;
                            end
                            if (!sd_oe) begin
                                e++;
                                sd_i = (e >= 2 && e <= 33) ? slave_word[33 - e] : 1'b0;
                            end
                        end else if (sd_o != prev_sd) tbad = 1;
                        highrun++;
                    end else begin
                        if (prev_sck) begin
                            if (highrun != HALF) tbad = 1;
                            highrun = 0;
                        end
                        lowrun++;
                    end
                end
                if (done) begin
                    if (q.size() == 0) begin
                        check(0, "R2 unexpected completion", 1, 0);
                    end else begin
                        cur = q.pop_front();
                        check(rises == cur.rises, "R7 rising edge count", rises, cur.rises);
                        check(cap == cur.frame, cur.wr ? "R3 write frame" : "R4 read frame",
                              cap, cur.frame);
                        check(!selbad, cur.wr ? "R3 select level" : "R4 select level", selbad, 0);
                        check(!tbad, "R5 bit timing", tbad, 0);
                        if (!cur.wr) check(!oebad, "R6 data released", oebad, 0);
                        check(rdata == cur.rdata, cur.wr ? "R10 rdata kept" : "R8/R9 read data",
                              rdata, cur.rdata);
                        check(!sel_oe && !sck_oe && !sd_oe && !sck_o, "R7 drivers released",
                              {sel_oe, sck_oe, sd_oe, sck_o}, 0);
                        check(pre_cnt == 3 * HALF + 2, "R11 first edge delay", pre_cnt, 3 * HALF + 2);
                    end
                    want_done_low = 1;
                end
                prev_sck  = sck_o;
                prev_busy = busy;
                prev_sd   = sd_o;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 busy/done", {busy, done}, 0);
        check(!sel_oe && !sck_oe && !sd_oe, "R1 enables", {sel_oe, sck_oe, sd_oe}, 0);
        check(!sel_o && !sck_o && rdata == 0, "R1 values", {sel_o, sck_o, rdata}, 0);

        issue(1'b1, 1'b0, 8'hA5, 16'h3C5A, 32'h0);
        // R2: a request during a transfer must be ignored
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h99; req_wdata = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;

        issue(1'b0, 1'b0, 8'h13, 16'h0, 32'hBEEF_1234);   // R8 odd address
        issue(1'b0, 1'b0, 8'h2C, 16'h0, 32'h55AA_C3C3);   // R8 even address
        issue(1'b0, 1'b1, 8'h7F, 16'h0, 32'h8000_0001);   // R9 full word
        issue(1'b1, 1'b0, 8'h00, 16'hFFFF, 32'h0);        // R10 rdata kept
        issue(1'b0, 1'b0, 8'hFF, 16'h0, 32'h1357_9BDF);   // R4 address bit 7 dropped
        issue(1'b1, 1'b1, 8'hFF, 16'h0001, 32'h0);        // R3 all-ones address

        while (q.size() != 0) @(negedge clk);
        repeat (50) @(negedge clk);
        check(!busy && q.size() == 0, "R2 no stray transfer", busy, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule